// File: doc/BRIEF.md
# Offset-Compressed Skewed Branch Target Buffer

This block is a last-level branch target buffer for an instruction-fetch front end. Most branch targets lie close to the branch itself. The buffer therefore stores a short signed distance from the branch address instead of the whole target address. Two such short records share one entry when both branches sit in the same 32-byte code region. A branch whose distance is too long for the short form uses the whole entry as one wide record that holds the complete target.

The array has two ways, and each way finds its set through its own function of the PC. Regions that collide in one way usually spread out in the other. With the default parameters each way has 1024 sets, so the array holds up to 4096 branches in the short form.

The fetch side presents a PC on the lookup port and gets a hit flag and the rebuilt target one cycle later. The resolve side writes a branch PC and its taken target through the update port. One update is accepted per cycle.

Top module: `compBtb`

## Requirements
- R1: After reset every lookup misses. `lkHit` and `lkTarget` are registered and reflect the lookup presented in the previous cycle. `lkTarget` is zero whenever `lkHit` is low.
- R2: The update computes `d = upTarget - upPc` in bytes, modulo 2^32. If `d` lies in -2048..+2047, the branch is stored in a compact slot as a 12-bit signed offset. A later hit returns the lookup PC plus the sign-extended offset.
- R3: If `d` is outside -2048..+2047, the region's entry becomes a full-format entry holding the whole 32-bit target. Any compact branches the entry held before are lost.
- R4: A region is identified by PC[31:5], and the position of a branch inside its region is PC[4:1]. One compact entry holds up to two branches of the same region at different positions. A lookup hits only on an exact region and position match.
- R5: A compact update to a region whose entry already holds two other positions drops the branch in slot 0. The branch in slot 1 moves to slot 0, and the new branch goes to slot 1.
- R6: An update for a position that is already stored replaces that branch's target and leaves the other slot untouched.
- R7: A compact-fitting update to a region held in full format turns the entry back into compact format, holding only the new branch.
- R8: Way 0 uses set index PC[14:5]. Way 1 uses PC[14:5] XOR PC[24:15]. Both ways are probed in parallel, so several regions that share a way-0 set can be held at once.
- R9: An update for a region not present allocates an entry. It takes way 0 if that way's candidate entry is empty, otherwise way 1 if that one is empty. Otherwise a global victim bit picks the way; this bit is 0 after reset and flips on every such forced choice.
- R10: A lookup made in the same cycle as an update sees the contents from before that update. A lookup in the following cycle sees the update.
- R11: When `lkValid` is low, `lkHit` is low in the next cycle, even for a stored PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request |
| lkPc | input | 32 | PC to look up |
| lkHit | output | 1 | Registered hit for the previous cycle's lookup |
| lkTarget | output | 32 | Registered predicted target, zero on miss |
| upValid | input | 1 | Update request |
| upPc | input | 32 | Branch PC to record |
| upTarget | input | 32 | Taken target of that branch |

## Verification
The bench goes after the offset range edges: +2047 and -2048 must stay compact, while +2048 and -2049 must force full format. A design with an off-by-one range check keeps the old neighbour visible or loses it a step early.

Slot handling is probed with a third branch in a full region, a rewrite of a stored position, and transitions between full and compact format in both directions. A design that fills the wrong slot, or does not evict on conversion, returns stale targets or drops the wrong neighbour.

Four regions that share one way-0 set must all hit. This exposes a design that uses the same index for both ways. A sequence of forced allocations then checks that the victim alternates starting with way 0. Finally, a lookup issued in the same cycle as its own update catches write-through leaking into the read.

// File: rtl/compBtbPkg.sv
package compBtbPkg;

  localparam int NWAYS = 2;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_NEW,
    ACT_FULL,
    ACT_SLOT0,
    ACT_SLOT1,
    ACT_SHIFT
  } updAct_e;

  // control -> datapath
  typedef struct packed {
    logic    wrEn;
    logic    wrWay;
    updAct_e act;
  } strobe_t;

  // datapath -> control, per way view of the update candidates
  typedef struct packed {
    logic [NWAYS-1:0]      entValid;
    logic [NWAYS-1:0]      regionHit;
    logic [NWAYS-1:0]      isFull;
    logic [NWAYS-1:0][1:0] slotV;
    logic [NWAYS-1:0][1:0] posMatch;
    logic                  fits;
  } upStat_t;

endpackage

// File: rtl/compBtbHash.sv
module compBtbHash #(
  parameter int IDX_W = 10,
  parameter int MIX   = 0
) (
  input  logic [IDX_W-1:0] lo,
  input  logic [IDX_W-1:0] hi,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] MASK = (MIX != 0) ? {IDX_W{1'b1}} : {IDX_W{1'b0}};

  assign idx = lo ^ (hi & MASK);
endmodule

// File: rtl/compBtbCtrl.sv
module compBtbCtrl
  import compBtbPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    upValid,
  input  upStat_t stat,
  output strobe_t strobes
);
  logic toggleQ;
  logic flip;
  logic hw;

  always_comb begin
    strobes.wrEn  = 1'b0;
    strobes.wrWay = 1'b0;
    strobes.act   = ACT_NONE;
    flip          = 1'b0;
    hw            = stat.regionHit[0] ? 1'b0 : 1'b1;
    if (upValid) begin
      strobes.wrEn = 1'b1;
      if (|stat.regionHit) begin
        strobes.wrWay = hw;
        if (!stat.fits)                                       strobes.act = ACT_FULL;
        else if (stat.isFull[hw])                             strobes.act = ACT_NEW;
        else if (stat.slotV[hw][0] && stat.posMatch[hw][0])   strobes.act = ACT_SLOT0;
        else if (stat.slotV[hw][1] && stat.posMatch[hw][1])   strobes.act = ACT_SLOT1;
        else if (!stat.slotV[hw][0])                          strobes.act = ACT_SLOT0;
        else if (!stat.slotV[hw][1])                          strobes.act = ACT_SLOT1;
        else                                                  strobes.act = ACT_SHIFT;
      end else begin
        if (!stat.entValid[0])      strobes.wrWay = 1'b0;
        else if (!stat.entValid[1]) strobes.wrWay = 1'b1;
        else begin
          strobes.wrWay = toggleQ;
          flip          = 1'b1;
        end
        strobes.act = stat.fits ? ACT_NEW : ACT_FULL;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     toggleQ <= 1'b0;
    else if (flip) toggleQ <= ~toggleQ;
  end
endmodule

// File: rtl/compBtbData.sv
module compBtbData
  import compBtbPkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int POS_W = 4,
  parameter int OFF_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lkValid,
  input  logic [PC_W-1:0] lkPc,
  output logic            lkHit,
  output logic [PC_W-1:0] lkTarget,
  input  logic [PC_W-1:0] upPc,
  input  logic [PC_W-1:0] upTarget,
  input  strobe_t         strobes,
  output upStat_t         stat
);
  localparam int SETS   = 1 << IDX_W;
  localparam int POS_LO = 1;
  localparam int IDX_LO = POS_LO + POS_W;
  localparam int TAG_LO = IDX_LO + IDX_W;
  localparam int TAG_W  = PC_W - TAG_LO;
  localparam int SLOT_W = 1 + POS_W + OFF_W;
  localparam int CMP_W  = 2 * SLOT_W;
  localparam int FULL_W = POS_W + PC_W;
  localparam int PAY_W  = (CMP_W > FULL_W) ? CMP_W : FULL_W;
  localparam int ENT_W  = 1 + TAG_W + PAY_W;

  logic [ENT_W-1:0] lkEnt [NWAYS];
  logic [ENT_W-1:0] upEnt [NWAYS];
  logic [NWAYS-1:0] lkVld, upVld;
  logic [ENT_W-1:0] newEnt;

  // probe one entry: returns {hit, target}
  function automatic logic [PC_W:0] probe(input logic [ENT_W-1:0] e, input logic v,
                                          input logic [PC_W-1:0] pc);
    logic [SLOT_W-1:0] s;
    logic              h;
    logic [PC_W-1:0]   t;
    h = 1'b0;
    t = '0;
    if (v && e[PAY_W +: TAG_W] == pc[PC_W-1:TAG_LO]) begin
      if (e[ENT_W-1]) begin
        if (e[PC_W +: POS_W] == pc[POS_LO +: POS_W]) begin
          h = 1'b1;
          t = e[0 +: PC_W];
        end
      end else begin
        for (int k = 0; k < 2; k++) begin
          s = e[k*SLOT_W +: SLOT_W];
          if (s[SLOT_W-1] && s[OFF_W +: POS_W] == pc[POS_LO +: POS_W]) begin
            h = 1'b1;
            t = pc + {{(PC_W-OFF_W){s[OFF_W-1]}}, s[OFF_W-1:0]};
          end
        end
      end
    end
    return {h, t};
  endfunction

  for (genvar w = 0; w < NWAYS; w++) begin : gWay
    logic [IDX_W-1:0] lkIdx, upIdx;
    logic [ENT_W-1:0] mem [SETS];
    logic [SETS-1:0]  vld;
    logic             wrHere;

    compBtbHash #(.IDX_W(IDX_W), .MIX(w)) u_lkHash (
      .lo(lkPc[IDX_LO +: IDX_W]), .hi(lkPc[TAG_LO +: IDX_W]), .idx(lkIdx));
    compBtbHash #(.IDX_W(IDX_W), .MIX(w)) u_upHash (
      .lo(upPc[IDX_LO +: IDX_W]), .hi(upPc[TAG_LO +: IDX_W]), .idx(upIdx));

    assign wrHere = strobes.wrEn && (strobes.wrWay == 1'(w));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       vld <= '0;
      else if (wrHere) vld[upIdx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wrHere) mem[upIdx] <= newEnt;
    end

    assign lkEnt[w] = mem[lkIdx];
    assign upEnt[w] = mem[upIdx];
    assign lkVld[w] = vld[lkIdx];
    assign upVld[w] = vld[upIdx];
  end

  // lookup side
  logic [PC_W:0] pr0, pr1;
  assign pr0 = probe(lkEnt[0], lkVld[0], lkPc);
  assign pr1 = probe(lkEnt[1], lkVld[1], lkPc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkHit    <= 1'b0;
      lkTarget <= '0;
    end else begin
      lkHit <= lkValid && (pr0[PC_W] || pr1[PC_W]);
      if (lkValid && pr0[PC_W])      lkTarget <= pr0[PC_W-1:0];
      else if (lkValid && pr1[PC_W]) lkTarget <= pr1[PC_W-1:0];
      else                           lkTarget <= '0;
    end
  end

  // update side
  logic [PC_W-1:0]   diff;
  logic [POS_W-1:0]  upPos;
  logic [TAG_W-1:0]  upTag;
  logic [SLOT_W-1:0] newSlot;
  logic [ENT_W-1:0]  base;

  assign diff    = upTarget - upPc;
  assign upPos   = upPc[POS_LO +: POS_W];
  assign upTag   = upPc[PC_W-1:TAG_LO];
  assign newSlot = {1'b1, upPos, diff[OFF_W-1:0]};

  always_comb begin
    stat      = '0;
    stat.fits = (&diff[PC_W-1:OFF_W-1]) || !(|diff[PC_W-1:OFF_W-1]);
    for (int w = 0; w < NWAYS; w++) begin
      stat.entValid[w]  = upVld[w];
      stat.regionHit[w] = upVld[w] && (upEnt[w][PAY_W +: TAG_W] == upTag);
      stat.isFull[w]    = upEnt[w][ENT_W-1];
      for (int k = 0; k < 2; k++) begin
        stat.slotV[w][k]    = upEnt[w][k*SLOT_W + SLOT_W - 1];
        stat.posMatch[w][k] = upEnt[w][k*SLOT_W + OFF_W +: POS_W] == upPos;
      end
    end
  end

  always_comb begin
    base   = upEnt[strobes.wrWay];
    newEnt = base;
    case (strobes.act)
      ACT_FULL: begin
        newEnt                 = '0;
        newEnt[ENT_W-1]        = 1'b1;
        newEnt[PAY_W +: TAG_W] = upTag;
        newEnt[PC_W +: POS_W]  = upPos;
        newEnt[0 +: PC_W]      = upTarget;
      end
      ACT_NEW: begin
        newEnt                 = '0;
        newEnt[PAY_W +: TAG_W] = upTag;
        newEnt[0 +: SLOT_W]    = newSlot;
      end
      ACT_SLOT0: newEnt[0 +: SLOT_W]      = newSlot;
      ACT_SLOT1: newEnt[SLOT_W +: SLOT_W] = newSlot;
      ACT_SHIFT: begin
        newEnt[0 +: SLOT_W]      = base[SLOT_W +: SLOT_W];
        newEnt[SLOT_W +: SLOT_W] = newSlot;
      end
      default: newEnt = base;
    endcase
  end
endmodule

// File: rtl/compBtb.sv
module compBtb
  import compBtbPkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int POS_W = 4,
  parameter int OFF_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lkValid,
  input  logic [PC_W-1:0] lkPc,
  output logic            lkHit,
  output logic [PC_W-1:0] lkTarget,
  input  logic            upValid,
  input  logic [PC_W-1:0] upPc,
  input  logic [PC_W-1:0] upTarget
);
  strobe_t strobes;
  upStat_t stat;

  compBtbCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .upValid(upValid), .stat(stat), .strobes(strobes));

  compBtbData #(.PC_W(PC_W), .IDX_W(IDX_W), .POS_W(POS_W), .OFF_W(OFF_W)) u_data (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkPc(lkPc), .lkHit(lkHit),
    .lkTarget(lkTarget), .upPc(upPc), .upTarget(upTarget), .strobes(strobes), .stat(stat));
endmodule

// File: rtl/compBtbChecker.sv
module compBtbChecker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkValid,
  input logic [PC_W-1:0] lkPc,
  input logic            lkHit,
  input logic [PC_W-1:0] lkTarget,
  input logic            upValid,
  input logic [PC_W-1:0] upPc,
  input logic [PC_W-1:0] upTarget,
  input logic            wrEn
);
  logic            prevV;
  logic [PC_W-1:0] prevPc, prevTgt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevV   <= 1'b0;
      prevPc  <= '0;
      prevTgt <= '0;
    end else begin
      prevV   <= upValid;
      prevPc  <= upPc;
      prevTgt <= upTarget;
    end
  end

  assert_hit_needs_request_R1: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> $past(lkValid));

  assert_miss_target_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> lkTarget == '0);

  assert_update_visible_R10: assert property (@(posedge clk) disable iff (!rstN)
    (prevV && lkValid && lkPc == prevPc) |=> (lkHit && lkTarget == $past(prevTgt)));

  assert_idle_no_hit_R11: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !lkHit);

  assert_update_writes_R9: assert property (@(posedge clk) disable iff (!rstN)
    upValid |-> wrEn);
endmodule

bind compBtb compBtbChecker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkPc(lkPc), .lkHit(lkHit),
  .lkTarget(lkTarget), .upValid(upValid), .upPc(upPc), .upTarget(upTarget),
  .wrEn(strobes.wrEn));

// File: tb/compBtb_bench.sv
`timescale 1ns/100ps
module compBtb_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic [31:0] lkPc = '0;
  logic        lkHit;
  logic [31:0] lkTarget;
  logic        upValid = 1'b0;
  logic [31:0] upPc = '0;
  logic [31:0] upTarget = '0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  compBtb u_compBtb (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkPc(lkPc), .lkHit(lkHit),
    .lkTarget(lkTarget), .upValid(upValid), .upPc(upPc), .upTarget(upTarget));

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] tgt);
    @(negedge clk);
    upValid = 1'b1; upPc = pc; upTarget = tgt;
    @(negedge clk);
    upValid = 1'b0;
  endtask

  task automatic look(input logic [31:0] pc, input logic expHit, input logic [31:0] expTgt,
                      input string req, input logic v = 1'b1);
    @(negedge clk);
    lkValid = v; lkPc = pc;
    @(negedge clk);
    lkValid = 1'b0;
    chk(req, $sformatf("hit pc=%h", pc), {31'b0, lkHit}, {31'b0, expHit});
    chk(req, $sformatf("target pc=%h", pc), lkTarget, expHit ? expTgt : 32'h0);
  endtask

  task automatic testReset();
    doReset();
    look(32'h1000, 1'b0, 0, "R1");
    upd(32'h1000, 32'h1100);
    look(32'h1000, 1'b1, 32'h1100, "R1");
    doReset();
    look(32'h1000, 1'b0, 0, "R1");
  endtask

  task automatic testRange();
    doReset();
    upd(32'h1000, 32'h1100);
    look(32'h1000, 1'b1, 32'h1100, "R2");
    upd(32'h3000, 32'h37FF);           // +2047 compact
    look(32'h3000, 1'b1, 32'h37FF, "R2");
    upd(32'h3002, 32'h3802);           // +2048 -> full, evicts 0x3000
    look(32'h3002, 1'b1, 32'h3802, "R3");
    look(32'h3000, 1'b0, 0, "R3");
    upd(32'h2004, 32'h1804);           // -2048 compact
    look(32'h2004, 1'b1, 32'h1804, "R2");
    upd(32'h2006, 32'h1805);           // -2049 -> full
    look(32'h2006, 1'b1, 32'h1805, "R3");
    look(32'h2004, 1'b0, 0, "R3");
  endtask

  task automatic testIdle();
    doReset();
    upd(32'h1000, 32'h1100);
    look(32'h1000, 1'b0, 0, "R11", 1'b0);
    look(32'h1000, 1'b1, 32'h1100, "R11");
  endtask

  task automatic testSlots();
    doReset();
    upd(32'h4000, 32'h4100);
    upd(32'h4002, 32'h4200);
    look(32'h4000, 1'b1, 32'h4100, "R4");
    look(32'h4002, 1'b1, 32'h4200, "R4");
    look(32'h4004, 1'b0, 0, "R4");
    look(32'h4020, 1'b0, 0, "R4");
    upd(32'h4006, 32'h4300);           // drops slot 0 (0x4000)
    look(32'h4000, 1'b0, 0, "R5");
    look(32'h4002, 1'b1, 32'h4200, "R5");
    look(32'h4006, 1'b1, 32'h4300, "R5");
    upd(32'h4008, 32'h4400);           // drops 0x4002
    look(32'h4002, 1'b0, 0, "R5");
    look(32'h4006, 1'b1, 32'h4300, "R5");
    look(32'h4008, 1'b1, 32'h4400, "R5");
  endtask

  task automatic testOverwrite();
    doReset();
    upd(32'h5000, 32'h5100);
    upd(32'h5002, 32'h5200);
    upd(32'h5000, 32'h4F00);
    look(32'h5000, 1'b1, 32'h4F00, "R6");
    look(32'h5002, 1'b1, 32'h5200, "R6");
  endtask

  task automatic testFormat();
    doReset();
    upd(32'h6000, 32'h6100);
    upd(32'h6002, 32'h6200);
    upd(32'h6004, 32'h8000_0000);
    look(32'h6000, 1'b0, 0, "R3");
    look(32'h6002, 1'b0, 0, "R3");
    look(32'h6004, 1'b1, 32'h8000_0000, "R3");
    upd(32'h6006, 32'h6016);
    look(32'h6004, 1'b0, 0, "R7");
    look(32'h6006, 1'b1, 32'h6016, "R7");
    upd(32'h7000_0000, 32'h10);
    look(32'h7000_0000, 1'b1, 32'h10, "R3");
  endtask

  task automatic testSkew();
    doReset();
    for (int i = 1; i <= 4; i++) upd(32'(i) << 15, (32'(i) << 15) + 32'h100);
    for (int i = 1; i <= 4; i++) look(32'(i) << 15, 1'b1, (32'(i) << 15) + 32'h100, "R8");
  endtask

  task automatic testVictim();
    doReset();
    upd(32'h0000_8000, 32'h0000_8040);   // way 0
    upd(32'h0200_8000, 32'h0200_8040);   // way 1
    upd(32'h0400_8000, 32'h0400_8040);   // forced, way 0
    look(32'h0000_8000, 1'b0, 0, "R9");
    look(32'h0200_8000, 1'b1, 32'h0200_8040, "R9");
    look(32'h0400_8000, 1'b1, 32'h0400_8040, "R9");
    upd(32'h0600_8000, 32'h0600_8040);   // forced, way 1
    look(32'h0200_8000, 1'b0, 0, "R9");
    look(32'h0400_8000, 1'b1, 32'h0400_8040, "R9");
    look(32'h0600_8000, 1'b1, 32'h0600_8040, "R9");
    upd(32'h0800_8000, 32'h0800_8040);   // forced, way 0 again
    look(32'h0400_8000, 1'b0, 0, "R9");
    look(32'h0600_8000, 1'b1, 32'h0600_8040, "R9");
    look(32'h0800_8000, 1'b1, 32'h0800_8040, "R9");
  endtask

  task automatic testSameCycle();
    doReset();
    @(negedge clk);
    upValid = 1'b1; upPc = 32'h9000; upTarget = 32'h9080;
    lkValid = 1'b1; lkPc = 32'h9000;
    @(negedge clk);
    upValid = 1'b0; lkValid = 1'b0;
    chk("R10", "same-cycle hit", {31'b0, lkHit}, 32'h0);
    look(32'h9000, 1'b1, 32'h9080, "R10");
  endtask

  initial begin
    testReset();
    testRange();
    testIdle();
    testSlots();
    testOverwrite();
    testFormat();
    testSkew();
    testVictim();
    testSameCycle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog (all R): actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule